// File: doc/BRIEF.md
# LCD Controller Power-On Setup Sequencer

This block sits on the host side of a parallel LCD controller bus. After system reset it waits for a start pulse. It then samples a mode input that selects between a 6800-style bus (enable strobe with a read/write line) and an 8080-style bus (separate active-low read and write strobes). The sequencer pulses the controller's reset line with the polarity that suits the selected bus style. It waits a recovery interval and then writes a fixed, ordered list of eight setup instructions. When the last write completes, it raises a done flag.

Each instruction write is built from three timed phases:

- a setup phase, in which chip select, the register-select line and the data byte become valid;
- a strobe phase, in which the strobe is active;
- a hold phase, in which data and chip select stay put after the latching edge.

The controller latches the byte on the falling edge of the enable strobe in 6800 mode, and on the rising edge of the write strobe in 8080 mode. A one-cycle bus-idle gap separates consecutive writes. The phase lengths, the reset pulse length and the recovery interval are parameters.

Top module: `lcd_init_seq`

## Requirements
- R1: After reset, and whenever the block is idle, chip select (`ctl_csn`) is 1 and the register-select line (`ctl_sel`) is 1. The enable strobe is 0 in 6800 mode. Both read and write strobes are 1 in 8080 mode. The reset line is at its inactive level for the mode selected by `bus_mode`. Before any start, `busy` and `done` are 0.
- R2: `bus_mode`=0 selects 6800 style and `bus_mode`=1 selects 8080 style. After start, `ctl_reset` is active for exactly RST_CYC cycles and then returns to its inactive level. It is active-low in 6800 mode and active-high in 8080 mode.
- R3: After the reset pulse ends, chip select stays high for exactly REC_CYC cycles before the first write begins.
- R4: Exactly eight instruction bytes are written, in this order: 0xAE, 0xC0, 0xA4, 0x00, 0xB8, 0xA9, 0xA0, 0xEE. These are: display off, start line 0, static drive off, column 0, page 0, 1/32 duty, forward column direction, and read-modify-write end.
- R5: During every write, `ctl_sel` is 0, which marks an instruction. Chip select is high for exactly one cycle between consecutive writes.
- R6: In 6800 mode, `ctl_rw_wrn` (read/write) is 0 throughout each write and 1 otherwise. `ctl_en_rdn` (enable) pulses high, and its falling edge is the latching edge.
- R7: In 8080 mode, `ctl_en_rdn` (read strobe) stays 1 at all times. `ctl_rw_wrn` (write strobe) pulses low, and its rising edge is the latching edge.
- R8: Each write holds chip select low with stable data for SETUP_CYC cycles before the strobe becomes active. The strobe stays active for PULSE_CYC cycles. Data and chip select then stay for HOLD_CYC cycles after the latching edge.
- R9: `busy` is 1 from the cycle after start until the sequence ends. `done` then rises, stays 1 with the bus idle, and holds until the next start.
- R10: A start pulse while `busy` is 1 is ignored: no second reset pulse and no extra or repeated write.
- R11: The mode is sampled when start is accepted. Changes of `bus_mode` during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the setup sequence (accepted when idle or done) |
| bus_mode | input | 1 | 0: 6800 style, 1: 8080 style |
| ctl_reset | output | 1 | Controller reset line, polarity by mode |
| ctl_csn | output | 1 | Chip select, active low |
| ctl_sel | output | 1 | Register select, 0 = instruction |
| ctl_en_rdn | output | 1 | Enable (6800) or read strobe (8080) |
| ctl_rw_wrn | output | 1 | Read/write (6800) or write strobe (8080) |
| ctl_dat | output | 8 | Instruction byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |

## Verification
A wrong step counter shows up at the latching edge of the very next write. It appears as a byte out of order, a repeated byte, or a ninth write, so the captured byte list exposes it within one write cycle. A wrong phase counter changes the measured setup, strobe or hold length of the write in progress. A wrong or unlatched mode shows as a reset line at the wrong level, or as a strobe on the wrong pin in the same cycle. The bench measures every write in both modes. It also toggles the mode input and fires stray start pulses during runs, so a mode that is not frozen, or a start that is not ignored, corrupts the capture of that run.

// File: rtl/lcd_init_pkg.sv
// Package: shared types and the setup script for the LCD setup sequencer.
// Assumes the script is fixed at eight instruction bytes issued in order.
package lcd_init_pkg;

    localparam int unsigned N_STEPS = 8;
    localparam int unsigned STEP_W  = $clog2(N_STEPS);

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RESET,
        SQ_RECOVER,
        SQ_RUN,
        SQ_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        WP_IDLE,
        WP_SETUP,
        WP_PULSE,
        WP_HOLD,
        WP_GAP
    } wr_phase_t;

    // Instruction byte for each step of the setup script.
    function automatic logic [7:0] script_byte(input logic [STEP_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'hAE;  // display off
            3'd1:    b = 8'hC0;  // start line 0
            3'd2:    b = 8'hA4;  // static drive off
            3'd3:    b = 8'h00;  // column 0
            3'd4:    b = 8'hB8;  // page 0
            3'd5:    b = 8'hA9;  // duty 1/32
            3'd6:    b = 8'hA0;  // forward column direction
            default: b = 8'hEE;  // read-modify-write end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_init_script.sv
// Module: lcd_init_script
// Maps a step index to its instruction byte. Purely combinational.
// Assumes the index never exceeds N_STEPS-1.
module lcd_init_script
    import lcd_init_pkg::*;
(
    input  logic [STEP_W-1:0] step_idx,
    output logic [7:0]        step_byte
);

    // Look up the byte for the requested step.
    always_comb begin
        step_byte = script_byte(step_idx);
    end

endmodule

// File: rtl/lcd_bus_writer.sv
// Module: lcd_bus_writer
// Runs one instruction write as setup, strobe and hold phases, followed
// by a one-cycle bus-idle gap. During the gap it can accept the next
// request back to back. The output is bus-neutral; pin mapping per mode
// happens elsewhere. Assumes every phase length is at least 1.
module lcd_bus_writer
    import lcd_init_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned PULSE_CYC = 3,
    parameter int unsigned HOLD_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] go_byte,
    output logic       ready,
    output logic       wr_done,
    output logic       in_cycle,
    output logic       strobe_on,
    output logic [7:0] bus_byte
);

    localparam int unsigned MAX_SP = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int unsigned MAX_PH = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
    localparam int unsigned CW     = $clog2(MAX_PH + 1);
    localparam logic [CW-1:0] SU_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PW_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HD_LAST = CW'(HOLD_CYC - 1);

    wr_phase_t   phase;
    logic [CW-1:0] cnt;
    logic [7:0]  byte_q;

    // Phase sequencing and byte capture for one write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= WP_IDLE;
            cnt    <= '0;
            byte_q <= '0;
        end else begin
            case (phase)
                WP_IDLE, WP_GAP: begin
                    if (go) begin
                        phase  <= WP_SETUP;
                        cnt    <= '0;
                        byte_q <= go_byte;
                    end else begin
                        phase <= WP_IDLE;
                    end
                end
                WP_SETUP: begin
                    if (cnt == SU_LAST) begin
                        phase <= WP_PULSE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                WP_PULSE: begin
                    if (cnt == PW_LAST) begin
                        phase <= WP_HOLD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                WP_HOLD: begin
                    if (cnt == HD_LAST) begin
                        phase <= WP_GAP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: phase <= WP_IDLE;
            endcase
        end
    end

    // Bus-neutral view of the write in progress.
    always_comb begin
        ready     = (phase == WP_IDLE) || (phase == WP_GAP);
        wr_done   = (phase == WP_GAP);
        in_cycle  = (phase == WP_SETUP) || (phase == WP_PULSE) || (phase == WP_HOLD);
        strobe_on = (phase == WP_PULSE);
        bus_byte  = in_cycle ? byte_q : 8'h00;
    end

    AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (phase == WP_IDLE || phase == WP_GAP)); // R10

    AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == WP_PULSE || phase == WP_HOLD) |-> $stable(byte_q)); // R8

    AST_PULSE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_on) |-> $past(phase) == WP_SETUP); // R8

endmodule

// File: rtl/lcd_init_ctrl.sv
// Module: lcd_init_ctrl
// Top-level sequencing: accepts start, latches the bus mode, times the
// reset pulse and recovery wait, then steps through the script by
// handing bytes to the writer. Assumes RST_CYC and REC_CYC are at least 1.
module lcd_init_ctrl
    import lcd_init_pkg::*;
#(
    parameter int unsigned RST_CYC = 16,
    parameter int unsigned REC_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bus_mode,
    input  logic              wr_done,
    input  logic              wr_ready,
    input  logic              wr_active,
    output logic              wr_go,
    output logic [STEP_W-1:0] wr_idx,
    output logic              mode_q,
    output logic              rst_active,
    output logic              busy,
    output logic              done
);

    localparam int unsigned MAX_T = (RST_CYC > REC_CYC) ? RST_CYC : REC_CYC;
    localparam int unsigned TW    = $clog2(MAX_T + 1);
    localparam logic [TW-1:0] RST_LAST = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] REC_LAST = TW'(REC_CYC - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(N_STEPS - 1);

    seq_state_t        state;
    logic [TW-1:0]     tcnt;
    logic [STEP_W-1:0] step;

    // Sequence state, timer, step index and mode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            tcnt   <= '0;
            step   <= '0;
            mode_q <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE, SQ_DONE: begin
                    mode_q <= bus_mode;
                    if (start) begin
                        state <= SQ_RESET;
                        tcnt  <= '0;
                    end
                end
                SQ_RESET: begin
                    if (tcnt == RST_LAST) begin
                        state <= SQ_RECOVER;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                SQ_RECOVER: begin
                    if (tcnt == REC_LAST) begin
                        state <= SQ_RUN;
                        step  <= '0;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                SQ_RUN: begin
                    if (wr_done) begin
                        if (step == STEP_LAST) begin
                            state <= SQ_DONE;
                        end else begin
                            step <= step + STEP_W'(1);
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Write requests: first one at the end of recovery, then one per gap.
    always_comb begin
        wr_go  = ((state == SQ_RECOVER) && (tcnt == REC_LAST)) ||
                 ((state == SQ_RUN) && wr_done && (step != STEP_LAST));
        wr_idx = (state == SQ_RUN) ? step + STEP_W'(1) : '0;
    end

    // Status decode.
    always_comb begin
        rst_active = (state == SQ_RESET);
        busy       = (state == SQ_RESET) || (state == SQ_RECOVER) || (state == SQ_RUN);
        done       = (state == SQ_DONE);
    end

    AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RESET || state == SQ_RECOVER) |-> !wr_active); // R3

    AST_GO_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> wr_ready); // R5

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q)); // R11

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(step) == STEP_LAST); // R4

endmodule

// File: rtl/lcd_pin_map.sv
// Module: lcd_pin_map
// Translates the bus-neutral write view into pin levels for the selected
// bus style and sets the reset line polarity. Purely combinational.
// Assumes mode_8080 is held stable for the whole run.
module lcd_pin_map (
    input  logic mode_8080,
    input  logic rst_active,
    input  logic in_cycle,
    input  logic strobe_on,
    output logic pin_reset,
    output logic pin_csn,
    output logic pin_sel,
    output logic pin_a,
    output logic pin_b
);

    // Reset polarity: active-high for 8080 style, active-low for 6800 style.
    always_comb begin
        pin_reset = mode_8080 ? rst_active : ~rst_active;
    end

    // Strobe, direction and select pins for each bus style.
    always_comb begin
        pin_csn = ~in_cycle;
        pin_sel = ~in_cycle;
        if (mode_8080) begin
            pin_a = 1'b1;          // read strobe never used
            pin_b = ~strobe_on;    // write strobe, low pulse
        end else begin
            pin_a = strobe_on;     // enable, high pulse
            pin_b = ~in_cycle;     // read/write low during a write
        end
    end

endmodule

// File: rtl/lcd_init_seq.sv
// Module: lcd_init_seq (top)
// Power-on setup sequencer for a parallel-bus LCD controller. Wires the
// control FSM, the script table, the write-cycle engine and the pin map.
// Assumes a synchronous active-low reset and all timing parameters >= 1.
module lcd_init_seq
    import lcd_init_pkg::*;
#(
    parameter int unsigned RST_CYC   = 16,
    parameter int unsigned REC_CYC   = 8,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned PULSE_CYC = 3,
    parameter int unsigned HOLD_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       bus_mode,
    output logic       ctl_reset,
    output logic       ctl_csn,
    output logic       ctl_sel,
    output logic       ctl_en_rdn,
    output logic       ctl_rw_wrn,
    output logic [7:0] ctl_dat,
    output logic       busy,
    output logic       done
);

    logic              wr_go;
    logic              wr_ready;
    logic              wr_done;
    logic              wr_active;
    logic              strobe_on;
    logic [STEP_W-1:0] wr_idx;
    logic [7:0]        next_byte;
    logic              mode_q;
    logic              rst_active;

    lcd_init_ctrl #(
        .RST_CYC (RST_CYC),
        .REC_CYC (REC_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .bus_mode   (bus_mode),
        .wr_done    (wr_done),
        .wr_ready   (wr_ready),
        .wr_active  (wr_active),
        .wr_go      (wr_go),
        .wr_idx     (wr_idx),
        .mode_q     (mode_q),
        .rst_active (rst_active),
        .busy       (busy),
        .done       (done)
    );

    lcd_init_script u_script (
        .step_idx  (wr_idx),
        .step_byte (next_byte)
    );

    lcd_bus_writer #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (wr_go),
        .go_byte   (next_byte),
        .ready     (wr_ready),
        .wr_done   (wr_done),
        .in_cycle  (wr_active),
        .strobe_on (strobe_on),
        .bus_byte  (ctl_dat)
    );

    lcd_pin_map u_pins (
        .mode_8080  (mode_q),
        .rst_active (rst_active),
        .in_cycle   (wr_active),
        .strobe_on  (strobe_on),
        .pin_reset  (ctl_reset),
        .pin_csn    (ctl_csn),
        .pin_sel    (ctl_sel),
        .pin_a      (ctl_en_rdn),
        .pin_b      (ctl_rw_wrn)
    );

    AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctl_csn && !busy)); // R9

    AST_SEL_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_csn |-> !ctl_sel); // R5

endmodule

// File: tb/test_lcd_init_seq.sv
// Bench for lcd_init_seq: directed runs in both bus modes, then seeded
// random runs with stray starts and mode toggles during the sequence.
module test_lcd_init_seq;

    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 16;
    localparam int REC_CYC    = 8;
    localparam int SU         = 2;
    localparam int PW         = 3;
    localparam int HD         = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       bus_mode = 1'b0;
    logic       ctl_reset, ctl_csn, ctl_sel, ctl_en_rdn, ctl_rw_wrn;
    logic [7:0] ctl_dat;
    logic       busy, done;

    int n_checks = 0;
    int n_fails  = 0;

    // Monitor state
    logic mon_en = 1'b0;
    logic mode_run = 1'b0;
    logic prev_act, prev_cs_n, prev_strobe;
    int   rst_len, rst_pulses, gap_cnt, gap_meas;
    logic gap_on;
    int   su_cnt, pw_cnt, hd_cnt;
    logic seen_strobe;
    logic [7:0] first_dat;
    int   timing_err, lvl_err, idle_err, unstable;
    logic [7:0] caught [0:15];
    int   n_caught;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_init_seq i_lcd_init_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .bus_mode   (bus_mode),
        .ctl_reset  (ctl_reset),
        .ctl_csn    (ctl_csn),
        .ctl_sel    (ctl_sel),
        .ctl_en_rdn (ctl_en_rdn),
        .ctl_rw_wrn (ctl_rw_wrn),
        .ctl_dat    (ctl_dat),
        .busy       (busy),
        .done       (done)
    );

    function automatic logic [7:0] exp_byte(input int i);
        case (i)
            0: return 8'hAE;
            1: return 8'hC0;
            2: return 8'hA4;
            3: return 8'h00;
            4: return 8'hB8;
            5: return 8'hA9;
            6: return 8'hA0;
            default: return 8'hEE;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        rst_len = 0; rst_pulses = 0; gap_cnt = 0; gap_meas = -1; gap_on = 1'b0;
        su_cnt = 0; pw_cnt = 0; hd_cnt = 0; seen_strobe = 1'b0; first_dat = 8'h00;
        timing_err = 0; lvl_err = 0; idle_err = 0; unstable = 0; n_caught = 0;
        prev_act = 1'b0; prev_cs_n = 1'b1; prev_strobe = 1'b0;
    endtask

    // Bus capture, sampled on the falling clock edge.
    always @(negedge clk) begin
        if (mon_en) begin
            logic act, strb;
            act  = mode_run ? ctl_reset : ~ctl_reset;
            strb = mode_run ? ~ctl_rw_wrn : ctl_en_rdn;
            if (act) begin
                rst_len++;
                if (!prev_act) rst_pulses++;
            end
            if (prev_act && !act) begin gap_on = 1'b1; gap_cnt = 0; end
            if (gap_on && !act) begin
                if (ctl_csn) gap_cnt++;
                else begin gap_meas = gap_cnt; gap_on = 1'b0; end
            end
            if (!ctl_csn) begin
                if (prev_cs_n) first_dat = ctl_dat;
                else if (ctl_dat != first_dat) unstable++;
                if (ctl_sel !== 1'b0) lvl_err++;                      // R5
                if (mode_run && ctl_en_rdn !== 1'b1) lvl_err++;       // R7
                if (!mode_run && ctl_rw_wrn !== 1'b0) lvl_err++;      // R6
                if (strb) begin pw_cnt++; seen_strobe = 1'b1; end
                else if (seen_strobe) hd_cnt++;
                else su_cnt++;
                if (prev_strobe && !strb) begin
                    if (n_caught < 16) caught[n_caught] = ctl_dat;
                    n_caught++;
                end
            end else begin
                if (!prev_cs_n) begin
                    if (su_cnt != SU || pw_cnt != PW || hd_cnt != HD) timing_err++;
                    su_cnt = 0; pw_cnt = 0; hd_cnt = 0; seen_strobe = 1'b0;
                end
                if (mode_run ? (ctl_en_rdn !== 1'b1 || ctl_rw_wrn !== 1'b1)
                             : (ctl_en_rdn !== 1'b0 || ctl_rw_wrn !== 1'b1)) idle_err++;
                if (ctl_sel !== 1'b1) idle_err++;
            end
            prev_act = act; prev_cs_n = ctl_csn; prev_strobe = strb;
        end
    end

    // One full run in the given mode; disturb adds stray starts and mode flips.
    task automatic run_seq(input logic mode, input logic disturb);
        int cyc;
        @(negedge clk);
        bus_mode = mode;
        repeat (2) @(negedge clk);
        check(ctl_reset == ~mode, "R1 reset idle level", ctl_reset, ~mode);
        check(ctl_csn == 1'b1 && busy == 1'b0, "R1 idle bus", {ctl_csn, busy}, 2'b10);
        clear_mon();
        mode_run = mode;
        mon_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R9 busy after start", {busy, done}, 2'b10);
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (disturb) begin
                start    = ($urandom_range(0, 5) == 0);
                bus_mode = $urandom_range(0, 1);
            end
        end
        start = 1'b0;
        bus_mode = mode;
        check(cyc < 2000, "R9 watchdog", cyc, 2000);
        repeat (4) @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R9 done holds", {done, busy}, 2'b10);
        check(rst_pulses == 1, "R10 single reset pulse", rst_pulses, 1);
        check(rst_len == RST_CYC, "R2 reset pulse length", rst_len, RST_CYC);
        check(ctl_reset == ~mode, "R2 reset returns inactive", ctl_reset, ~mode);
        check(gap_meas == REC_CYC, "R3 recovery gap", gap_meas, REC_CYC);
        check(n_caught == 8, "R4 write count", n_caught, 8);
        for (int i = 0; i < 8; i++)
            check(caught[i] == exp_byte(i), "R4 byte order", caught[i], exp_byte(i));
        check(timing_err == 0, "R8 setup/strobe/hold", timing_err, 0);
        check(unstable == 0, "R8 data stable", unstable, 0);
        if (mode) check(lvl_err == 0, "R7 8080 pin levels", lvl_err, 0);
        else      check(lvl_err == 0, "R6 6800 pin levels", lvl_err, 0);
        check(idle_err == 0, "R1 idle levels between writes", idle_err, 0);
        if (disturb) check(lvl_err == 0 && rst_pulses == 1, "R11 mode frozen", lvl_err, 0);
        mon_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1dc4));
        repeat (3) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R1 reset state", {done, busy}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctl_csn == 1'b1 && ctl_reset == 1'b1 && ctl_en_rdn == 1'b0 && ctl_rw_wrn == 1'b1,
              "R1 pins after reset", {ctl_csn, ctl_reset, ctl_en_rdn, ctl_rw_wrn}, 4'b1101);
        run_seq(1'b0, 1'b0);   // R6 directed 6800
        run_seq(1'b1, 1'b0);   // R7 directed 8080
        run_seq(1'b1, 1'b1);   // R10 R11 directed disturb
        for (int k = 0; k < 6; k++) begin
            repeat ($urandom_range(1, 20)) @(negedge clk);
            run_seq(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule